// File: doc/BRIEF.md
# Keypad Alarm Arming Controller

This block is the decision core of a keypad-operated home alarm. Each clock cycle it samples an entry strobe and a flag telling whether the code just typed was right. A right code on an entry arms the system when it is off and disarms it when it is watching. A single wrong entry while watching is remembered. A second wrong entry in a row trips the alarm. Once tripped, only reset can clear it.

The block is a four-state Moore machine. Its single output is the alarm line, which depends only on the current state. Code storage, digit capture, debouncing and the siren driver are handled elsewhere. The entry strobe is assumed to be already synchronous and one cycle wide per key press. Every cycle in which it is high counts as a separate entry.

Top module: `alarm_arm_ctrl`

## Requirements
- R1: An active-high synchronous reset puts the state register at 2'b00 (disarmed) with alarm_o low. Reset takes priority over any entry sampled at the same edge.
- R2: In the disarmed state (2'b00), an entry with the code flag high moves to the watching state (2'b01).
- R3: In the watching state, an entry with the code flag high returns the machine to disarmed.
- R4: In the watching state, an entry with the code flag low moves to the one-miss state (2'b10).
- R5: In the one-miss state, an entry with the code flag low moves to the tripped state (2'b11).
- R6: In the one-miss state, an entry with the code flag high returns the machine to disarmed and discards the earlier miss.
- R7: The tripped state is absorbing. No entry, right or wrong, leaves it; only reset does.
- R8: When the entry strobe is low, the disarmed, watching and one-miss states hold. In the disarmed state, an entry with the code flag low also holds.
- R9: alarm_o is high in the tripped state and low in the other three states. It changes in the cycle after the edge that changes the state.
- R10: Each cycle with the entry strobe high is one entry. Two back-to-back wrong strobe cycles while watching trip the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Active-high synchronous reset |
| enter_i | input | 1 | Entry strobe, one entry per high cycle |
| code_ok_i | input | 1 | High when the entered code matches |
| alarm_o | output | 1 | High while the alarm is tripped |

## Verification
Reset and an entry can land on the same clock edge. The bench provokes this by holding reset high while it also presents a right-code entry in the disarmed state. It then proves the machine is still disarmed: two following wrong entries must leave alarm_o low, whereas an armed machine would trip. A second collision is a right-code entry presented while tripped, which must leave alarm_o high. Since the state is seen only through alarm_o, each state transition is judged by a follow-up sequence whose alarm result differs between the candidate states.

// File: rtl/alarm_arm_pkg.sv
package alarm_arm_pkg;
   localparam int unsigned ST_W = 2;

   typedef enum logic [ST_W-1:0] {
      ST_DISARMED = 2'b00,
      ST_WATCHING = 2'b01,
      ST_ONE_MISS = 2'b10,
      ST_TRIPPED  = 2'b11
   } arm_state_e;
endpackage

// File: rtl/alarm_next_state.sv
module alarm_next_state
   import alarm_arm_pkg::*;
(
   input  arm_state_e cur_i,
   input  logic       enter_i,
   input  logic       code_ok_i,
   output arm_state_e nxt_o
);
   always_comb begin
      nxt_o = cur_i;
      if (enter_i) begin
         unique case (cur_i)
            ST_DISARMED: nxt_o = code_ok_i ? ST_WATCHING : ST_DISARMED;
            ST_WATCHING: nxt_o = code_ok_i ? ST_DISARMED : ST_ONE_MISS;
            ST_ONE_MISS: nxt_o = code_ok_i ? ST_DISARMED : ST_TRIPPED;
            ST_TRIPPED:  nxt_o = ST_TRIPPED;
            default:     nxt_o = ST_DISARMED;
         endcase
      end
   end
endmodule

// File: rtl/alarm_out_decode.sv
module alarm_out_decode
   import alarm_arm_pkg::*;
(
   input  arm_state_e st_i,
   output logic       alarm_o
);
   always_comb alarm_o = (st_i == ST_TRIPPED);
endmodule

// File: rtl/alarm_arm_ctrl.sv
module alarm_arm_ctrl
   import alarm_arm_pkg::*;
#(
   parameter int unsigned STATE_BITS = 2
)(
   input  logic clk,
   input  logic rst,
   input  logic enter_i,
   input  logic code_ok_i,
   output logic alarm_o
);
   localparam int unsigned N_STATES = 1 << STATE_BITS;

   generate
      if (STATE_BITS != ST_W || N_STATES != 4) begin : g_bad_width
         $error("alarm_arm_ctrl: STATE_BITS must be 2");
      end
   endgenerate

   arm_state_e st_q, st_d;

   alarm_next_state u_next (
      .cur_i     (st_q),
      .enter_i   (enter_i),
      .code_ok_i (code_ok_i),
      .nxt_o     (st_d)
   );

   always_ff @(posedge clk) begin
      if (rst) st_q <= ST_DISARMED;
      else     st_q <= st_d;
   end

   alarm_out_decode u_dec (
      .st_i    (st_q),
      .alarm_o (alarm_o)
   );

   assert_reset_disarms_R1: assert property (@(posedge clk)
      rst |=> (st_q == ST_DISARMED && !alarm_o));

   assert_arm_R2: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_DISARMED && enter_i && code_ok_i) |=> (st_q == ST_WATCHING));

   assert_second_miss_trips_R5: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_ONE_MISS && enter_i && !code_ok_i) |=> alarm_o);

   assert_tripped_absorbs_R7: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_TRIPPED) |=> (st_q == ST_TRIPPED));

   assert_idle_holds_R8: assert property (@(posedge clk) disable iff (rst)
      !enter_i |=> $stable(st_q));

   assert_alarm_rise_R9: assert property (@(posedge clk) disable iff (rst)
      $rose(alarm_o) |-> ($past(st_q) == ST_ONE_MISS));
endmodule

// File: tb/test_alarm_arm_ctrl.sv
module test_alarm_arm_ctrl;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic enter_i = 1'b0;
   logic code_ok_i = 1'b0;
   logic alarm_o;
   int   n_run = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   always #5 clk = ~clk;

   alarm_arm_ctrl i_alarm_arm_ctrl (
      .clk(clk), .rst(rst), .enter_i(enter_i),
      .code_ok_i(code_ok_i), .alarm_o(alarm_o)
   );

   task automatic chk(input string req, input logic exp);
      n_run++;
      if (alarm_o !== exp) begin
         n_fail++;
         $display("FAIL %s: alarm_o=%b expected %b", req, alarm_o, exp);
      end
   endtask

   task automatic press(input logic e, input logic ok);
      @(negedge clk);
      enter_i = e; code_ok_i = ok;
      @(posedge clk);
      #2;
      enter_i = 1'b0; code_ok_i = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      #2 rst = 1'b0;
   endtask

   task automatic t_reset_state();
      do_reset();
      chk("R1 reset", 1'b0);
      press(1, 0); press(1, 0);
      chk("R1 reset leaves disarmed", 1'b0);
   endtask

   task automatic t_arm_and_trip();
      do_reset();
      press(1, 1);
      chk("R2 armed no alarm", 1'b0);
      press(1, 0);
      chk("R4 one miss no alarm", 1'b0);
      press(1, 0);
      chk("R5 second miss trips", 1'b1);
   endtask

   task automatic t_disarm();
      do_reset();
      press(1, 1); press(1, 1);
      press(1, 0); press(1, 0);
      chk("R3 disarmed ignores misses", 1'b0);
   endtask

   task automatic t_miss_cleared();
      do_reset();
      press(1, 1); press(1, 0); press(1, 1);
      chk("R6 right code after miss", 1'b0);
      press(1, 0); press(1, 0);
      chk("R6 back to disarmed", 1'b0);
      press(1, 1); press(1, 0);
      chk("R6 miss record cleared", 1'b0);
      press(1, 0);
      chk("R6 fresh arm trips", 1'b1);
   endtask

   task automatic t_absorb();
      do_reset();
      press(1, 1); press(1, 0); press(1, 0);
      press(1, 1);
      chk("R7 right code while tripped", 1'b1);
      press(1, 0); press(0, 0);
      chk("R7 stays tripped", 1'b1);
      do_reset();
      chk("R7 reset clears", 1'b0);
   endtask

   task automatic t_hold();
      do_reset();
      press(1, 0); press(1, 0); press(0, 1);
      press(1, 1);
      for (int i = 0; i < 4; i++) press(0, 1);
      press(1, 0);
      for (int i = 0; i < 4; i++) press(0, 0);
      chk("R8 one miss held", 1'b0);
      press(1, 0);
      chk("R8 watching and miss held", 1'b1);
   endtask

   task automatic t_back_to_back();
      do_reset();
      press(1, 1);
      @(negedge clk);
      enter_i = 1'b1; code_ok_i = 1'b0;
      @(posedge clk); #2;
      chk("R9 alarm low after first miss", 1'b0);
      @(posedge clk); #2;
      enter_i = 1'b0;
      chk("R10 two strobe cycles trip", 1'b1);
   endtask

   task automatic t_reset_collision();
      do_reset();
      @(negedge clk);
      rst = 1'b1; enter_i = 1'b1; code_ok_i = 1'b1;
      @(posedge clk); #2;
      rst = 1'b0; enter_i = 1'b0; code_ok_i = 1'b0;
      press(1, 0); press(1, 0);
      chk("R1 reset beats entry", 1'b0);
   endtask

   initial begin
      fork
         begin
            repeat (20000) @(posedge clk);
            if (!done) begin
               n_run++; n_fail++;
               $display("FAIL watchdog: expired expected completion");
               $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
               $finish;
            end
         end
      join_none
      t_reset_state();
      t_arm_and_trip();
      t_disarm();
      t_miss_cleared();
      t_absorb();
      t_hold();
      t_back_to_back();
      t_reset_collision();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule